// File: doc/BRIEF.md
# DMA Channel Interrupt Status Controller

This block gathers interrupt events from the channel engines of a multi-channel DMA unit and presents them to software through a small word-addressed register port. Each channel can report four kinds of event. Two are completion events: the whole descriptor chain has finished, or a single descriptor that asked for a node interrupt has finished. The other two are separate error classes. Every event class keeps a sticky raw latch per channel, an enable mask per channel and a masked view. The masked views are merged into one combined per-channel pending vector, and a single registered interrupt line goes to the CPU.

Software enables classes by writing their masks and acknowledges events by writing ones to the raw registers. When a channel is torn down, its four raw bits are cleared with one write per class. Channel i owns bit i of every event register. The channel count is a parameter, up to 16.

Top module: `dma_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on bit i of an event input sets bit i of that class's raw register at the next clock edge. The raw register stays set until it is cleared. Register word indices are addr[7:2], with addr[1:0] ignored. Raw registers are at indices 9..12 for the classes chain-done, node-done, error A and error B, in that order.
- R2: Writing a raw register clears every bit written as 1. Bits written as 0 keep their value.
- R3: The mask registers are read/write at indices 5..8, in the same class order, and reset to zero. A mask bit of 1 enables that channel's event in that class. Writing zero disables the whole class.
- R4: If a set pulse and a clearing write hit the same raw bit in the same cycle, the bit ends up set.
- R5: The read-only registers at indices 1..4 return raw AND mask for each class.
- R6: The read-only register at index 0 returns, for each channel, the OR of that channel's four masked bits.
- R7: After four raw writes with only bit i set, one per class, channel i has no raw bit set and its combined bit is 0. This holds unless new events arrive during the writes.
- R8: The irq output equals the OR of the combined vector as it stood one cycle earlier.
- R9: A read strobe returns data on reg_rdata in the next cycle. The value reflects the state before any write in the same cycle. Without a read strobe, reg_rdata is 0.
- R10: Reads of indices 13 and above return 0. Writes to read-only or unmapped indices change no state. Data bits at and above the channel count read as 0.
- R11: After synchronous reset, all raw and mask bits are 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_chain_done | input | NCH | Per-channel whole-chain completion pulses |
| ev_node_done | input | NCH | Per-channel flagged-descriptor completion pulses |
| ev_err_a | input | NCH | Per-channel error class A pulses |
| ev_err_b | input | NCH | Per-channel error class B pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address, word index in bits 7:2 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |
| irq | output | 1 | Combined interrupt to the CPU |

## Verification
The bench goes after the cycle where an event pulse and a one-to-clear write hit the same bit. A design that let the clear win would lose that event, and the raw and combined reads would then come back zero. It mixes zero and one bits in clearing writes, so that a design which cleared whole words, or which treated zero as clear, shows raw bits vanishing. It also writes to the status and unmapped indices: a decoder that aliased them onto the masks or raw latches would change what later reads return. A behavioural model checks every clock that irq lags the combined state by exactly one cycle and that read data reflects the state before a same-cycle write, which catches an extra or missing register stage.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int NCLS = 4;

    typedef enum logic [1:0] {
        EV_CHAIN = 2'd0,
        EV_NODE  = 2'd1,
        EV_ERRA  = 2'd2,
        EV_ERRB  = 2'd3
    } ev_class_e;

    typedef enum logic [2:0] {
        RG_COMB,
        RG_MSKD,
        RG_MASK,
        RG_RAW,
        RG_NONE
    } region_e;

    typedef struct packed {
        region_e   region;
        ev_class_e cls;
    } reg_dec_t;

    localparam logic [5:0] IDX_COMB = 6'd0;
    localparam logic [5:0] IDX_MSKD = 6'd1;
    localparam logic [5:0] IDX_MASK = 6'd5;
    localparam logic [5:0] IDX_RAW  = 6'd9;
    localparam logic [5:0] IDX_END  = 6'd13;

    function automatic reg_dec_t decode_idx(input logic [5:0] idx);
        reg_dec_t   d;
        logic [5:0] off;
        d.region = RG_NONE;
        off      = '0;
        if (idx == IDX_COMB) begin
            d.region = RG_COMB;
        end else if (idx < IDX_MASK) begin
            d.region = RG_MSKD;
            off      = idx - IDX_MSKD;
        end else if (idx < IDX_RAW) begin
            d.region = RG_MASK;
            off      = idx - IDX_MASK;
        end else if (idx < IDX_END) begin
            d.region = RG_RAW;
            off      = idx - IDX_RAW;
        end
        d.cls = ev_class_e'(off[1:0]);
        return d;
    endfunction

endpackage

// File: rtl/dma_irq_class.sv
module dma_irq_class #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] evt,
    input  logic           mask_we,
    input  logic           raw_we,
    input  logic [NCH-1:0] wdata,
    output logic [NCH-1:0] raw,
    output logic [NCH-1:0] mask,
    output logic [NCH-1:0] masked
);

    logic [NCH-1:0] clr_vec;
    logic [NCH-1:0] raw_nxt;

    always_comb begin
        clr_vec = raw_we ? wdata : '0;
        raw_nxt = (raw & ~clr_vec) | evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw  <= '0;
            mask <= '0;
        end else begin
            raw <= raw_nxt;
            if (mask_we) mask <= wdata;
        end
    end

    assign masked = raw & mask;

    // R1 R4
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((raw & $past(evt)) == $past(evt)));

    // R2
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        raw_we |=> ((raw & $past(wdata & ~evt)) == '0));

    // R2
    raw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((raw ^ $past(raw)) & ~$past(clr_vec | evt)) == '0));

    // R3
    mask_wr_chk: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> (mask == $past(wdata)));

    // R3
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mask_we |=> $stable(mask));

endmodule

// File: rtl/dma_irq_regread.sv
module dma_irq_regread
    import dma_irq_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rd_en,
    input  reg_dec_t                  dec,
    input  logic [NCLS-1:0][NCH-1:0]  raw_all,
    input  logic [NCLS-1:0][NCH-1:0]  mask_all,
    input  logic [NCLS-1:0][NCH-1:0]  mskd_all,
    input  logic [NCH-1:0]            comb,
    output logic [DATA_W-1:0]         rdata
);

    logic [NCH-1:0]    sel;
    logic [DATA_W-1:0] word;

    always_comb begin
        unique case (dec.region)
            RG_COMB: sel = comb;
            RG_MSKD: sel = mskd_all[dec.cls];
            RG_MASK: sel = mask_all[dec.cls];
            RG_RAW:  sel = raw_all[dec.cls];
            default: sel = '0;
        endcase
        word          = '0;
        word[NCH-1:0] = sel;
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_en ? word : '0;
    end

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rdata == '0));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && dec.region == RG_NONE) |=> (rdata == '0));

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dma_irq_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    ev_chain_done,
    input  logic [NCH-1:0]    ev_node_done,
    input  logic [NCH-1:0]    ev_err_a,
    input  logic [NCH-1:0]    ev_err_b,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    logic [NCLS-1:0][NCH-1:0] ev_all;
    logic [NCLS-1:0][NCH-1:0] raw_all;
    logic [NCLS-1:0][NCH-1:0] mask_all;
    logic [NCLS-1:0][NCH-1:0] mskd_all;
    logic [NCH-1:0]           comb;
    reg_dec_t                 dec;

    assign ev_all[EV_CHAIN] = ev_chain_done;
    assign ev_all[EV_NODE]  = ev_node_done;
    assign ev_all[EV_ERRA]  = ev_err_a;
    assign ev_all[EV_ERRB]  = ev_err_b;

    assign dec = decode_idx(reg_addr[7:2]);

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        logic mask_we;
        logic raw_we;
        assign mask_we = reg_wr && dec.region == RG_MASK && dec.cls == ev_class_e'(c);
        assign raw_we  = reg_wr && dec.region == RG_RAW  && dec.cls == ev_class_e'(c);

        dma_irq_class #(.NCH(NCH)) u_cls (
            .clk     (clk),
            .rst     (rst),
            .evt     (ev_all[c]),
            .mask_we (mask_we),
            .raw_we  (raw_we),
            .wdata   (reg_wdata[NCH-1:0]),
            .raw     (raw_all[c]),
            .mask    (mask_all[c]),
            .masked  (mskd_all[c])
        );
    end

    always_comb begin
        comb = '0;
        for (int c = 0; c < NCLS; c++) comb = comb | mskd_all[c];
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |comb;
    end

    dma_irq_regread #(.NCH(NCH), .DATA_W(DATA_W)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (reg_rd),
        .dec      (dec),
        .raw_all  (raw_all),
        .mask_all (mask_all),
        .mskd_all (mskd_all),
        .comb     (comb),
        .rdata    (reg_rdata)
    );

    // R8
    irq_lag_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past(|comb)));

    // R6
    comb_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_all == '0) |-> (comb == '0));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (irq == 1'b0 && raw_all == '0 && mask_all == '0));

endmodule

// File: tb/dma_irq_ctrl_test.sv
module dma_irq_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ev_c = '0, ev_n = '0, ev_a = '0, ev_b = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R11";

    logic [15:0] m_raw [4];
    logic [15:0] m_mask[4];
    logic [31:0] exp_rdata = '0;
    logic        exp_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_ctrl #(.NCH(NCH)) uut (
        .clk(clk), .rst(rst),
        .ev_chain_done(ev_c), .ev_node_done(ev_n), .ev_err_a(ev_a), .ev_err_b(ev_b),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // behavioural reference: evaluate reads and irq on old state, then update
    always @(posedge clk) begin
        logic [15:0] ev[4];
        logic [15:0] cm;
        int idx;
        ev[0] = ev_c; ev[1] = ev_n; ev[2] = ev_a; ev[3] = ev_b;
        if (rst) begin
            for (int c = 0; c < 4; c++) begin m_raw[c] = '0; m_mask[c] = '0; end
            exp_rdata = '0;
            exp_irq   = 1'b0;
        end else begin
            cm = '0;
            for (int c = 0; c < 4; c++) cm |= m_raw[c] & m_mask[c];
            idx = int'(reg_addr[7:2]);
            exp_rdata = '0;
            if (reg_rd) begin
                if (idx == 0)                    exp_rdata[15:0] = cm;
                else if (idx >= 1 && idx <= 4)   exp_rdata[15:0] = m_raw[idx-1] & m_mask[idx-1];
                else if (idx >= 5 && idx <= 8)   exp_rdata[15:0] = m_mask[idx-5];
                else if (idx >= 9 && idx <= 12)  exp_rdata[15:0] = m_raw[idx-9];
            end
            exp_irq = (cm != 0);
            for (int c = 0; c < 4; c++) begin
                if (reg_wr && idx == 9 + c) m_raw[c] = m_raw[c] & ~reg_wdata[15:0];
                m_raw[c] = m_raw[c] | ev[c];
                if (reg_wr && idx == 5 + c) m_mask[c] = reg_wdata[15:0];
            end
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (reg_rdata !== exp_rdata) begin
                errors++;
                $display("FAIL %s rdata actual=%h expected=%h t=%0t", cur_req, reg_rdata, exp_rdata, $time);
            end
            checks++;
            if (irq !== exp_irq) begin
                errors++;
                $display("FAIL %s (R8 irq) actual=%b expected=%b t=%0t", cur_req, irq, exp_irq, $time);
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; ev_c = 0; ev_n = 0; ev_a = 0; ev_b = 0;
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_rd = 0; reg_addr = 8'(idx << 2); reg_wdata = d;
        ev_c = 0; ev_n = 0; ev_a = 0; ev_b = 0;
    endtask

    task automatic rd(input int idx);
        @(negedge clk);
        reg_wr = 0; reg_rd = 1; reg_addr = 8'(idx << 2) | 8'($urandom_range(0, 3));
        ev_c = 0; ev_n = 0; ev_a = 0; ev_b = 0;
    endtask

    task automatic rd_all();
        for (int i = 0; i < 16; i++) rd(i);
        idle();
    endtask

    task automatic pulse(input logic [15:0] c, input logic [15:0] n,
                         input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; ev_c = c; ev_n = n; ev_a = a; ev_b = b;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        cur_req = "R11"; rd_all();

        cur_req = "R1";  pulse(16'h0001, 16'h0100, 16'h8000, 16'h0010); rd_all();
        cur_req = "R3";  wr(5, 32'hFFFF_FFFF); wr(6, 32'h0000_0100); wr(7, 32'h8000); wr(8, 32'h0); rd_all();
        cur_req = "R5";  rd(1); rd(2); rd(3); rd(4); idle();
        cur_req = "R6";  rd(0); idle(); idle();
        cur_req = "R2";  wr(9, 32'h0000_0000); wr(10, 32'hFFFF_FEFF); rd_all();
        cur_req = "R4";
        @(negedge clk);
        reg_wr = 1; reg_rd = 0; reg_addr = 8'(9 << 2); reg_wdata = 32'h0003;
        ev_c = 16'h0002; ev_n = 0; ev_a = 0; ev_b = 0;
        rd(9); rd(0); idle();
        cur_req = "R10"; wr(0, 32'hFFFF); wr(2, 32'hFFFF); wr(13, 32'hFFFF); wr(40, 32'hFFFF);
        rd(13); rd(20); rd(63); rd_all();
        cur_req = "R7";  wr(5, 32'hFFFF); wr(6, 32'hFFFF); wr(7, 32'hFFFF); wr(8, 32'hFFFF);
        pulse(16'h0020, 16'h0020, 16'h0020, 16'h0020); rd(0); idle();
        wr(9, 32'h0020); wr(10, 32'h0020); wr(11, 32'h0020); wr(12, 32'h0020); rd(0); rd_all();
        cur_req = "R3";  wr(5, 32'h0); wr(6, 32'h0); wr(7, 32'h0); wr(8, 32'h0);
        pulse(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF); rd(0); rd_all();
        cur_req = "R9";  wr(5, 32'hFFFF); rd(9); rd(5); idle();

        cur_req = "R8 mixed";
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            ev_c = 16'($urandom) & 16'($urandom) & 16'($urandom);
            ev_n = 16'($urandom) & 16'($urandom) & 16'($urandom);
            ev_a = 16'($urandom) & 16'($urandom) & 16'($urandom) & 16'($urandom);
            ev_b = 16'($urandom) & 16'($urandom) & 16'($urandom) & 16'($urandom);
            reg_wr = ($urandom_range(0, 2) == 0);
            reg_rd = ($urandom_range(0, 1) == 0);
            reg_addr = 8'($urandom_range(0, 15) << 2);
            reg_wdata = $urandom;
        end
        idle();
        rd_all();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule